// File: doc/BRIEF.md
# External Bus Strobe Generator

This block produces the two timing strobes of a classic multiplexed external memory bus: the address-latch strobe, which tells external logic when to capture the low address byte, and the program-read strobe, which fetches code from external program memory. Both strobes come from a phase counter. The counter steps once for each oscillator tick and wraps after a full machine cycle of twelve phases.

The address-latch strobe normally fires twice per machine cycle. It drops its second pulse in a cycle that performs an external data access. A software-owned disable bit can mute the strobe except during external data or code-table move instructions. That bit is ignored while code runs from external memory.

The program-read strobe fires twice per machine cycle during external execution, between the latch pulses. Both of its activations are suppressed during an external data access. Pulse positions and widths are parameters. Both strobes are active high and registered, so they change only on clock edges where the oscillator tick is high.

Top module: `ext_bus_strobe_gen`

## Requirements
- R1: A phase counter runs from 0 to PHASES-1 (default 12). It advances by one on each clock edge with `osc_tick` high and wraps from the last phase to 0. With default parameters, 24 consecutive ticks in normal operation give exactly 8 cycles of `ale_out` high.
- R2: On a clock edge with `osc_tick` low, neither strobe and not the phase counter change.
- R3: After reset the phase is 0 and both strobes are low. The first tick enters phase 1.
- R4: With the latch strobe enabled and no data access, `ale_out` is high in phases 0–1 and 6–7 (ALE_W=2 phases starting at each half-cycle boundary) and low otherwise.
- R5: While `xdata_cycle` is high, the latch pulse of the second half-cycle (phases 6–7) is omitted, and the pulse at phases 0–1 is kept.
- R6: With `ale_off` high and `ext_exec` low, `ale_out` is high only in a latch phase during which `move_instr` is high.
- R7: With `ext_exec` high, `ale_off` has no effect on `ale_out`.
- R8: With `ext_exec` high and `xdata_cycle` low, `psen_out` is high in phases 3–5 and 9–11 (PSEN_W=3 phases, offset PSEN_OFS=3 into each half-cycle) and low otherwise.
- R9: `psen_out` is low whenever `ext_exec` is low or `xdata_cycle` is high.
- R10: `ale_out` and `psen_out` are never high at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_tick | input | 1 | Oscillator period enable; advances the phase |
| xdata_cycle | input | 1 | Current machine cycle accesses external data memory |
| move_instr | input | 1 | An external data or code-table move instruction is executing |
| ale_off | input | 1 | Latch-strobe disable bit from a control register |
| ext_exec | input | 1 | Code is fetched from external program memory |
| ale_out | output | 1 | Address-latch strobe, active high |
| psen_out | output | 1 | Program-read strobe, active high |

## Verification
The assertions assume that the control flags are sampled together with the phase step. Strobe values follow the flags present on the ticking edge, not any earlier value, and the flags hold steady within a clock period. The stimulus changes every input only at the falling clock edge, so each rising edge sees one settled set of flags. Random runs toggle the tick and all four flags freely, including combinations that real instruction flow never produces, such as a data access during external execution with the disable bit set. Directed runs cover reset, tick-free edges and the two-machine-cycle pulse count.

// File: rtl/ebs_pkg.sv
package ebs_pkg;
   // Decide whether a phase lies in the window [start, start+width).
   // The width parameter is used so a wrap past PHASES never happens.
   function automatic logic phase_in_window(input int unsigned ph,
                                            input int unsigned start,
                                            input int unsigned width);
      return (ph >= start) && (ph < start + width);
   endfunction
endpackage

// File: rtl/ebs_phase_ctr.sv
module ebs_phase_ctr #(
   parameter int PHASES = 12,
   localparam int CNT_W = $clog2(PHASES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             osc_tick,
   output logic [CNT_W-1:0] phase_q,
   output logic [CNT_W-1:0] phase_nxt
);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(PHASES - 1);

   if (PHASES < 4) begin : g_bad_phases
      $error("ebs_phase_ctr: PHASES must be at least 4");
   end

   always_comb begin
      if (phase_q == LAST) phase_nxt = '0;
      else                 phase_nxt = phase_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        phase_q <= '0;
      else if (osc_tick) phase_q <= phase_nxt;
   end

   AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      phase_q <= LAST); // R1
   AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (osc_tick && phase_q != LAST) |=> phase_q == $past(phase_q) + 1'b1); // R1
   AST_PHASE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (osc_tick && phase_q == LAST) |=> phase_q == '0); // R1
   AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !osc_tick |=> $stable(phase_q)); // R2
endmodule

// File: rtl/ebs_slot_bank.sv
module ebs_slot_bank #(
   parameter int PHASES = 12,
   parameter int SLOTS  = 2,
   parameter int OFFSET = 0,
   parameter int WIDTH  = 2,
   localparam int CNT_W = $clog2(PHASES),
   localparam int SPAN  = PHASES / SLOTS
) (
   input  logic [CNT_W-1:0] phase,
   output logic [SLOTS-1:0] slot_hit
);
   import ebs_pkg::*;

   if (WIDTH < 1 || OFFSET + WIDTH > SPAN) begin : g_bad_window
      $error("ebs_slot_bank: window does not fit within one slot");
   end

   for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      localparam int START = s * SPAN + OFFSET;
      assign slot_hit[s] = phase_in_window(int'(phase), START, WIDTH);
   end
endmodule

// File: rtl/ext_bus_strobe_gen.sv
module ext_bus_strobe_gen #(
   parameter int PHASES   = 12,
   parameter int SLOTS    = 2,
   parameter int ALE_W    = 2,
   parameter int PSEN_OFS = 3,
   parameter int PSEN_W   = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic osc_tick,
   input  logic xdata_cycle,
   input  logic move_instr,
   input  logic ale_off,
   input  logic ext_exec,
   output logic ale_out,
   output logic psen_out
);
   localparam int CNT_W     = $clog2(PHASES);
   localparam int SPAN      = PHASES / SLOTS;
   localparam int LAST_SLOT = SLOTS - 1;

   if (SLOTS < 2 || PHASES % SLOTS != 0) begin : g_bad_slots
      $error("ext_bus_strobe_gen: PHASES must split evenly into at least two slots");
   end
   if (ALE_W > PSEN_OFS) begin : g_bad_overlap
      $error("ext_bus_strobe_gen: latch pulse would overlap the read strobe");
   end

   logic [CNT_W-1:0] phase_q, phase_nxt;
   logic [SLOTS-1:0] ale_hit, psen_hit, ale_keep;
   logic             ale_allowed, ale_d, psen_d;

   ebs_phase_ctr #(.PHASES(PHASES)) u_ctr (
      .clk      (clk),
      .rst_n    (rst_n),
      .osc_tick (osc_tick),
      .phase_q  (phase_q),
      .phase_nxt(phase_nxt)
   );

   ebs_slot_bank #(.PHASES(PHASES), .SLOTS(SLOTS), .OFFSET(0), .WIDTH(ALE_W)) u_ale_slots (
      .phase   (phase_nxt),
      .slot_hit(ale_hit)
   );

   ebs_slot_bank #(.PHASES(PHASES), .SLOTS(SLOTS), .OFFSET(PSEN_OFS), .WIDTH(PSEN_W)) u_psen_slots (
      .phase   (phase_nxt),
      .slot_hit(psen_hit)
   );

   // A data access drops only the final latch pulse of the machine cycle.
   for (genvar s = 0; s < SLOTS; s++) begin : g_keep
      if (s == LAST_SLOT) begin : g_last
         assign ale_keep[s] = !xdata_cycle;
      end else begin : g_other
         assign ale_keep[s] = 1'b1;
      end
   end

   assign ale_allowed = !ale_off || ext_exec || move_instr;
   assign ale_d       = ale_allowed && |(ale_hit & ale_keep);
   assign psen_d      = ext_exec && !xdata_cycle && |psen_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ale_out  <= 1'b0;
         psen_out <= 1'b0;
      end else if (osc_tick) begin
         ale_out  <= ale_d;
         psen_out <= psen_d;
      end
   end

   AST_STROBE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !osc_tick |=> ($stable(ale_out) && $stable(psen_out))); // R2
   AST_ALE_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
      (osc_tick && xdata_cycle) |=> !(ale_out && int'(phase_q) >= LAST_SLOT * SPAN)); // R5
   AST_ALE_MUTED: assert property (@(posedge clk) disable iff (!rst_n)
      (osc_tick && ale_off && !ext_exec && !move_instr) |=> !ale_out); // R6
   AST_PSEN_XDATA: assert property (@(posedge clk) disable iff (!rst_n)
      (osc_tick && (xdata_cycle || !ext_exec)) |=> !psen_out); // R9
   AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(ale_out && psen_out)); // R10
endmodule

// File: tb/tb_ext_bus_strobe_gen.sv
module tb_ext_bus_strobe_gen;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 100000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic osc_tick = 1'b0, xdata_cycle = 1'b0, move_instr = 1'b0;
   logic ale_off = 1'b0, ext_exec = 1'b0;
   logic ale_out, psen_out;

   int checks = 0;
   int fails  = 0;
   int ph     = 0;
   int cycles = 0;
   bit done   = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ext_bus_strobe_gen dut (
      .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .xdata_cycle(xdata_cycle),
      .move_instr(move_instr), .ale_off(ale_off), .ext_exec(ext_exec),
      .ale_out(ale_out), .psen_out(psen_out)
   );

   function automatic bit exp_ale(int p, bit xd, bit mv, bit dis, bit ext);
      bit en = !dis || ext || mv;
      return en && ((p < 2) || (p >= 6 && p < 8 && !xd));
   endfunction

   function automatic bit exp_psen(int p, bit xd, bit ext);
      return ext && !xd && ((p >= 3 && p < 6) || (p >= 9));
   endfunction

   task automatic check(string tag, string what, bit act, bit exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%0b expected=%0b phase=%0d", tag, what, act, exp, ph);
      end
   endtask

   bit prev_ale = 0, prev_psen = 0;

   task automatic step(bit t, bit xd, bit mv, bit dis, bit ext);
      string ta, tp;
      bit ea, ep;
      @(negedge clk);
      osc_tick = t; xdata_cycle = xd; move_instr = mv; ale_off = dis; ext_exec = ext;
      @(posedge clk);
      #1;
      if (t) begin
         ph = (ph + 1) % 12;
         ea = exp_ale(ph, xd, mv, dis, ext);
         ep = exp_psen(ph, xd, ext);
         if (dis && !ext)      ta = "R6";
         else if (dis && ext)  ta = "R7";
         else if (xd)          ta = "R5";
         else                  ta = "R4";
         tp = (ext && !xd) ? "R8" : "R9";
      end else begin
         ea = prev_ale; ep = prev_psen;
         ta = "R2"; tp = "R2";
      end
      check(ta, "ale_out", ale_out, ea);
      check(tp, "psen_out", psen_out, ep);
      check("R10", "strobe overlap", ale_out && psen_out, 1'b0);
      prev_ale = ea; prev_psen = ep;
   endtask

   initial begin
      while (!done && cycles < WATCHDOG) begin
         @(posedge clk);
         cycles++;
      end
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      int unsigned seed = 32'd7321;
      int ale_count;
      void'($urandom(seed));
      repeat (3) @(negedge clk);
      #1;
      check("R3", "ale_out in reset", ale_out, 1'b0);
      check("R3", "psen_out in reset", psen_out, 1'b0);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      check("R3", "ale_out after reset", ale_out, 1'b0);
      check("R3", "psen_out after reset", psen_out, 1'b0);

      // First tick enters phase 1: latch strobe high, read strobe low.
      step(1, 0, 0, 0, 1);
      check("R3", "first tick ale", ale_out, 1'b1);

      // Tick-free edges freeze the strobes.
      repeat (5) step(0, 1, 1, 1, 0);

      // R1: two full machine cycles give 8 latch-high cycles.
      ale_count = 0;
      repeat (24) begin
         step(1, 0, 0, 0, 0);
         ale_count += ale_out;
      end
      checks++;
      if (ale_count != 8) begin
         fails++;
         $display("FAIL R1 ale high count actual=%0d expected=8", ale_count);
      end

      // Directed corners: data access, disabled latch with/without move, external override.
      repeat (12) step(1, 1, 0, 0, 1);
      repeat (12) step(1, 0, 0, 1, 0);
      repeat (12) step(1, 0, 1, 1, 0);
      repeat (12) step(1, 0, 0, 1, 1);
      repeat (12) step(1, 1, 1, 1, 0);

      // Constrained random mix.
      for (int i = 0; i < 3000; i++) begin
         bit t  = ($urandom % 4) != 0;
         bit xd = ($urandom % 3) == 0;
         bit mv = ($urandom % 3) == 0;
         bit ds = ($urandom % 2) == 0;
         bit ex = ($urandom % 2) == 0;
         step(t, xd, mv, ds, ex);
      end

      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule